// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block runs 32-bit integer multiplication and division over many clock cycles for a processor execute stage. The surrounding pipeline presents a source operand, a destination operand and an operation select, then pulses `start`. The unit raises `busy`. Some cycles later it pulses `done` for one cycle. With that pulse it returns a primary word for the destination register and a secondary word for the fixed auxiliary register r30. It also returns new overflow, sign and zero flags, and a write enable for each of the three outputs. A division by zero produces an exception request instead of any write. The carry flag is not an output of the unit, so all five operations leave it untouched.

The datapath is one shared radix-2 engine that processes one bit per cycle. Multiplication uses shift-and-add on operand magnitudes. Division uses restoring shift-and-subtract on operand magnitudes. Operand signs are recorded before the first iteration and applied in a separate fix-up cycle.

The controller has four states. IDLE waits for `start`; a start seen there is accepted and moves to RUN. RUN performs one iteration per cycle for W cycles and then moves to FIX. FIX applies sign correction, computes the flags and registers the outputs, then moves to DONE. DONE presents the outputs for exactly one cycle and returns to IDLE.

Top module: `muldiv_iter`

## Requirements
- R1: Operation code 0 (signed multiply) returns the low W bits of the signed 2W-bit product as the result and the high W bits as the auxiliary result. OV is set when the product is outside the signed W-bit range, S is the result MSB and Z is set when the result is zero. All three write enables are asserted.
- R2: Operation code 1 (unsigned multiply) behaves like R1 with both operands treated as unsigned. OV is set exactly when the high product word is nonzero.
- R3: Operation code 2 (signed divide) divides the destination operand by the source operand with truncation toward zero. The quotient is the result and the remainder is the auxiliary result, with the sign of the dividend. OV is cleared and S and Z follow the quotient.
- R4: Operation code 3 (unsigned divide) behaves like R3 with both operands treated as unsigned.
- R5: A divide (code 2 or 3) by a zero source operand asserts `exc_req` with `exc_code` 0xFF80. No write enable is asserted.
- R6: A signed divide of the most negative value by all-ones returns result 0x8000_0000 (MSB only) and auxiliary 0, with OV=1, S=1 and Z=0. No exception is raised.
- R7: Operation code 4 (halfword multiply) returns the low W bits of the destination operand times the low W/2+1 bits of the source operand sign-extended. Only the result write enable is asserted; auxiliary and flags are not written.
- R8: Operation codes 5 to 7 complete with no write enable and no exception request.
- R9: When `start` is sampled in IDLE, `done` is high for exactly one cycle, W+2 rising edges later. `busy` is high from the cycle after that start through the done cycle and low afterwards. Write enables and `exc_req` are only high together with `done`.
- R10: A `start` pulse, new operands or a new operation code applied while `busy` is high do not affect the running operation.
- R11: During and after reset, `busy`, `done`, all write enables and `exc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only in IDLE) |
| op | input | 3 | Operation select (0..4 defined) |
| src_val | input | W | Source operand: multiplier or divisor |
| dst_val | input | W | Destination operand: multiplicand or dividend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Product low word or quotient |
| aux_result | output | W | Product high word or remainder (for r30) |
| res_we | output | 1 | Write result to destination |
| aux_we | output | 1 | Write aux_result to r30 |
| flags_we | output | 1 | Update OV, S, Z |
| flag_ov | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| exc_req | output | 1 | Exception request |
| exc_code | output | 16 | Exception cause code |

## Verification
The bench uses an 8-bit instance and sweeps every operation code over a grid of operands. The grid includes zero, one, the most negative value, the most positive value and all-ones. Mishandled sign fix-up would show up as a wrong remainder sign for negative dividends or a wrong product for mixed-sign operands. A unit that trapped on the most negative value divided by minus one, or left OV clear there, would miss the R6 vector. A zero-divisor path that still wrote registers would assert a write enable beside `exc_req`. A further test changes inputs and pulses `start` mid-operation; a controller that reloaded there would return the intruder's result.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam logic [2:0] OP_MULS = 3'd0;
    localparam logic [2:0] OP_MULU = 3'd1;
    localparam logic [2:0] OP_DIVS = 3'd2;
    localparam logic [2:0] OP_DIVU = 3'd3;
    localparam logic [2:0] OP_MULH = 3'd4;

    localparam logic [15:0] EXC_ZERO_DIV = 16'hFF80;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIX  = 2'd2,
        S_DONE = 2'd3
    } md_state_e;

    // Operation context captured when an operation is accepted
    typedef struct packed {
        logic [2:0] op;
        logic       neg_main;   // negate product / quotient
        logic       neg_rem;    // negate remainder
        logic       div_zero;   // divisor is zero
        logic       min_neg1;   // signed most-negative / -1
    } md_ctx_t;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
    import muldiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int HB = W / 2 + 1
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic [W-1:0] mag_src,
    output logic [W-1:0] mag_dst,
    output md_ctx_t      ctx
);

    logic [W-1:0] src_eff;
    logic         is_signed;
    logic         is_div;
    logic         src_neg;
    logic         dst_neg;

    always_comb begin
        src_eff   = (op == OP_MULH) ? {{(W-HB){src[HB-1]}}, src[HB-1:0]} : src;
        is_signed = (op == OP_MULS) || (op == OP_DIVS) || (op == OP_MULH);
        is_div    = (op == OP_DIVS) || (op == OP_DIVU);
        src_neg   = is_signed && src_eff[W-1];
        dst_neg   = is_signed && dst[W-1];
        mag_src   = src_neg ? (~src_eff + 1'b1) : src_eff;
        mag_dst   = dst_neg ? (~dst + 1'b1) : dst;

        ctx.op       = op;
        ctx.neg_main = src_neg ^ dst_neg;
        ctx.neg_rem  = dst_neg;
        ctx.div_zero = is_div && (src == '0);
        ctx.min_neg1 = (op == OP_DIVS) && (dst == {1'b1, {(W-1){1'b0}}})
                       && (src == '1);
    end

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         is_div,
    input  logic [W-1:0] ld_src,
    input  logic [W-1:0] ld_dst,
    output logic [W-1:0] word_hi,
    output logic [W-1:0] word_lo
);

    logic [W-1:0] opnd_q;   // multiplicand or divisor magnitude
    logic [W-1:0] hi_q;     // product high / partial remainder
    logic [W-1:0] lo_q;     // multiplier / quotient bits

    logic [W:0]   add_sum;
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         fits;

    always_comb begin
        add_sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, opnd_q} : '0);
        shifted = {hi_q, lo_q[W-1]};
        diff    = {1'b0, shifted} - {2'b00, opnd_q};
        fits    = ~diff[W+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (load) begin
            opnd_q <= ld_src;
            hi_q   <= '0;
            lo_q   <= ld_dst;
        end else if (step) begin
            if (is_div) begin
                hi_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                lo_q <= {lo_q[W-2:0], fits};
            end else begin
                hi_q <= add_sum[W:1];
                lo_q <= {add_sum[0], lo_q[W-1:1]};
            end
        end
    end

    assign word_hi = hi_q;
    assign word_lo = lo_q;

endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_ctx_t      ctx,
    input  logic [W-1:0] word_hi,
    input  logic [W-1:0] word_lo,
    output logic [W-1:0] res,
    output logic [W-1:0] aux,
    output logic         ov,
    output logic         sgn,
    output logic         zro,
    output logic         res_we,
    output logic         aux_we,
    output logic         flg_we,
    output logic         exc
);

    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;

    always_comb begin
        prod   = ctx.neg_main ? (~{word_hi, word_lo} + 1'b1) : {word_hi, word_lo};
        quo    = ctx.neg_main ? (~word_lo + 1'b1) : word_lo;
        rem    = ctx.neg_rem  ? (~word_hi + 1'b1) : word_hi;
        res    = '0;
        aux    = '0;
        ov     = 1'b0;
        res_we = 1'b0;
        aux_we = 1'b0;
        flg_we = 1'b0;
        exc    = 1'b0;
        case (ctx.op)
            OP_MULS, OP_MULU: begin
                res    = prod[W-1:0];
                aux    = prod[2*W-1:W];
                ov     = (ctx.op == OP_MULS) ? (prod[2*W-1:W] != {W{prod[W-1]}})
                                             : (prod[2*W-1:W] != '0);
                res_we = 1'b1;
                aux_we = 1'b1;
                flg_we = 1'b1;
            end
            OP_DIVS, OP_DIVU: begin
                if (ctx.div_zero) begin
                    exc = 1'b1;
                end else begin
                    res    = quo;
                    aux    = rem;
                    ov     = ctx.min_neg1;
                    res_we = 1'b1;
                    aux_we = 1'b1;
                    flg_we = 1'b1;
                end
            end
            OP_MULH: begin
                res    = prod[W-1:0];
                res_we = 1'b1;
            end
            default: ;
        endcase
        sgn = res[W-1];
        zro = (res == '0);
    end

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] src_val,
    input  logic [W-1:0] dst_val,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] aux_result,
    output logic         res_we,
    output logic         aux_we,
    output logic         flags_we,
    output logic         flag_ov,
    output logic         flag_s,
    output logic         flag_z,
    output logic         exc_req,
    output logic [15:0]  exc_code
);

    localparam int HB = W / 2 + 1;
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    md_state_e     state_q;
    logic [CW-1:0] step_cnt_q;
    md_ctx_t       ctx_q;
    md_ctx_t       ctx_n;
    logic [W-1:0]  mag_src;
    logic [W-1:0]  mag_dst;
    logic [W-1:0]  word_hi;
    logic [W-1:0]  word_lo;
    logic          accept;

    logic [W-1:0]  fx_res, fx_aux;
    logic          fx_ov, fx_s, fx_z, fx_rwe, fx_awe, fx_fwe, fx_exc;

    logic [W-1:0]  res_q, aux_q;
    logic          ov_q, s_q, z_q, rwe_q, awe_q, fwe_q, exc_q;

    assign accept = (state_q == S_IDLE) && start;

    muldiv_prep #(.W(W), .HB(HB)) prep_i (
        .op      (op),
        .src     (src_val),
        .dst     (dst_val),
        .mag_src (mag_src),
        .mag_dst (mag_dst),
        .ctx     (ctx_n)
    );

    muldiv_core #(.W(W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state_q == S_RUN),
        .is_div  ((ctx_q.op == OP_DIVS) || (ctx_q.op == OP_DIVU)),
        .ld_src  (mag_src),
        .ld_dst  (mag_dst),
        .word_hi (word_hi),
        .word_lo (word_lo)
    );

    muldiv_fixup #(.W(W)) fix_i (
        .ctx     (ctx_q),
        .word_hi (word_hi),
        .word_lo (word_lo),
        .res     (fx_res),
        .aux     (fx_aux),
        .ov      (fx_ov),
        .sgn     (fx_s),
        .zro     (fx_z),
        .res_we  (fx_rwe),
        .aux_we  (fx_awe),
        .flg_we  (fx_fwe),
        .exc     (fx_exc)
    );

    // State register: IDLE -> RUN -> FIX -> DONE -> IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            step_cnt_q <= '0;
            ctx_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    ctx_q      <= ctx_n;
                    step_cnt_q <= '0;
                    state_q    <= S_RUN;
                end
                S_RUN: begin
                    step_cnt_q <= step_cnt_q + 1'b1;
                    if (step_cnt_q == LAST_STEP) state_q <= S_FIX;
                end
                S_FIX:  state_q <= S_DONE;
                S_DONE: state_q <= S_IDLE;
            endcase
        end
    end

    // Result capture at the end of the fix-up cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0; aux_q <= '0;
            ov_q <= 1'b0; s_q <= 1'b0; z_q <= 1'b0;
            rwe_q <= 1'b0; awe_q <= 1'b0; fwe_q <= 1'b0; exc_q <= 1'b0;
        end else if (state_q == S_FIX) begin
            res_q <= fx_res; aux_q <= fx_aux;
            ov_q <= fx_ov; s_q <= fx_s; z_q <= fx_z;
            rwe_q <= fx_rwe; awe_q <= fx_awe; fwe_q <= fx_fwe; exc_q <= fx_exc;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_DONE);
        result     = res_q;
        aux_result = aux_q;
        flag_ov    = ov_q;
        flag_s     = s_q;
        flag_z     = z_q;
        res_we     = done && rwe_q;
        aux_we     = done && awe_q;
        flags_we   = done && fwe_q;
        exc_req    = done && exc_q;
        exc_code   = exc_req ? EXC_ZERO_DIV : 16'h0000;
    end

endmodule

// File: rtl/muldiv_iter_chk.sv
module muldiv_iter_chk
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   op,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] aux_result,
    input logic         res_we,
    input logic         aux_we,
    input logic         flags_we,
    input logic         flag_ov,
    input logic         flag_s,
    input logic         flag_z,
    input logic         exc_req,
    input logic [15:0]  exc_code
);

    localparam int LAT_EXP = W + 2;

    logic [2:0] op_q;
    int         lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= 3'd0;
            lat_q <= 0;
        end else if (start && !busy) begin
            op_q  <= op;
            lat_q <= 1;
        end else if (busy) begin
            lat_q <= lat_q + 1;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LAT_EXP));

    // R9
    we_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || aux_we || flags_we || exc_req) |-> done);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (!res_we && !aux_we && !flags_we && exc_code == 16'hFF80));

    // R7
    half_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MULH) |-> (res_we && !aux_we && !flags_we));

    // R6
    min_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags_we && flag_ov && op_q == OP_DIVS) |->
        (result == {1'b1, {(W-1){1'b0}}} && aux_result == '0 && flag_s && !flag_z));

    // R2
    mulu_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MULU) |-> (flag_ov == (aux_result != '0)));

endmodule

bind muldiv_iter muldiv_iter_chk #(.W(W)) chk_i (.*);

// File: tb/muldiv_iter_tb_top.sv
module muldiv_iter_tb_top;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [BW-1:0] src_val = '0;
    logic [BW-1:0] dst_val = '0;
    logic          busy, done, res_we, aux_we, flags_we;
    logic          flag_ov, flag_s, flag_z, exc_req;
    logic [BW-1:0] result, aux_result;
    logic [15:0]   exc_code;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    muldiv_iter #(.W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_val(src_val), .dst_val(dst_val),
        .busy(busy), .done(done), .result(result), .aux_result(aux_result),
        .res_we(res_we), .aux_we(aux_we), .flags_we(flags_we),
        .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z),
        .exc_req(exc_req), .exc_code(exc_code)
    );

    function automatic longint sx8(input logic [7:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint sx5(input logic [4:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [7:0] pick(input int i);
        if (i < 16) return 8'(i * 17);
        case (i)
            16: return 8'h80;
            17: return 8'h7F;
            18: return 8'h01;
            default: return 8'hFE;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [7:0] a,
                         input logic [7:0] b, input bit poke);
        logic [7:0] e_res, e_aux;
        bit e_rwe, e_awe, e_fwe, e_exc, e_ov, e_s, e_z;
        longint p, q, r;
        string tag;
        int cnt;
        bit ok;
        e_res = '0; e_aux = '0;
        e_rwe = 0; e_awe = 0; e_fwe = 0; e_exc = 0; e_ov = 0;
        tag = "R8";
        case (o)
            3'd0: begin
                tag = "R1";
                p = sx8(b) * sx8(a);
                e_res = p[7:0]; e_aux = p[15:8];
                e_ov = (p != sx8(p[7:0]));
                e_rwe = 1; e_awe = 1; e_fwe = 1;
            end
            3'd1: begin
                tag = "R2";
                p = longint'({56'b0, b}) * longint'({56'b0, a});
                e_res = p[7:0]; e_aux = p[15:8];
                e_ov = (e_aux != 0);
                e_rwe = 1; e_awe = 1; e_fwe = 1;
            end
            3'd2: begin
                tag = "R3";
                if (a == 0) begin
                    tag = "R5"; e_exc = 1;
                end else if (b == 8'h80 && a == 8'hFF) begin
                    tag = "R6";
                    e_res = 8'h80; e_aux = 8'h00; e_ov = 1;
                    e_rwe = 1; e_awe = 1; e_fwe = 1;
                end else begin
                    q = sx8(b) / sx8(a);
                    r = sx8(b) % sx8(a);
                    e_res = q[7:0]; e_aux = r[7:0];
                    e_rwe = 1; e_awe = 1; e_fwe = 1;
                end
            end
            3'd3: begin
                tag = "R4";
                if (a == 0) begin
                    tag = "R5"; e_exc = 1;
                end else begin
                    q = longint'({56'b0, b}) / longint'({56'b0, a});
                    r = longint'({56'b0, b}) % longint'({56'b0, a});
                    e_res = q[7:0]; e_aux = r[7:0];
                    e_rwe = 1; e_awe = 1; e_fwe = 1;
                end
            end
            3'd4: begin
                tag = "R7";
                p = sx8(b) * sx5(a[4:0]);
                e_res = p[7:0];
                e_rwe = 1;
            end
            default: ;
        endcase
        e_s = e_res[7];
        e_z = (e_res == 0);
        if (poke) tag = "R10";

        @(negedge clk);
        start = 1'b1; op = o; src_val = a; dst_val = b;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        check(busy === 1'b1, "R9", "busy after start", longint'(busy), 1);
        while (done !== 1'b1 && cnt < 40) begin
            if (poke && cnt == 3) begin
                start = 1'b1; op = 3'd3; src_val = 8'h03; dst_val = 8'h77;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(cnt == BW + 2, "R9", "done latency", cnt, BW + 2);
        ok = (res_we === e_rwe) && (aux_we === e_awe) && (flags_we === e_fwe)
             && (exc_req === e_exc)
             && (!e_rwe || result === e_res)
             && (!e_awe || aux_result === e_aux)
             && (!e_fwe || (flag_ov === e_ov && flag_s === e_s && flag_z === e_z))
             && (!e_exc || exc_code === 16'hFF80);
        check(ok, tag, $sformatf("op%0d a=%02h b=%02h {we,exc,res,aux,ov,s,z}", o, a, b),
              longint'({res_we, aux_we, flags_we, exc_req, result, aux_result, flag_ov, flag_s, flag_z}),
              longint'({e_rwe, e_awe, e_fwe, e_exc, e_res, e_aux, e_ov, e_s, e_z}));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && res_we === 1'b0 && exc_req === 1'b0,
              "R9", "idle after done", longint'({busy, done, res_we, exc_req}), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs quiet while held in reset
        check({busy, done, res_we, aux_we, flags_we, exc_req} === 6'b0, "R11",
              "in reset", longint'({busy, done, res_we, aux_we, flags_we, exc_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, done, res_we, aux_we, flags_we, exc_req} === 6'b0, "R11",
              "after reset", longint'({busy, done, res_we, aux_we, flags_we, exc_req}), 0);

        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 20; i++)
                for (int j = 0; j < 20; j++)
                    apply(3'(o), pick(i), pick(j), 1'b0);

        // R10: intruding start with other operands mid-operation
        apply(3'd0, 8'h12, 8'hF3, 1'b1);
        apply(3'd2, 8'hFD, 8'h65, 1'b1);
        apply(3'd4, 8'h1B, 8'h2C, 1'b1);
        apply(3'd3, 8'h00, 8'h40, 1'b1);

        finish_run();
    end

endmodule